// File: doc/BRIEF.md
# Display Controller Command Parser

This block sits behind the host interface of a graphic display controller and turns a stream of bytes into configuration state. Each byte arrives with a valid strobe and a flag that marks it as a command (opcode) or as data (a parameter). The parser decodes the opcode and knows how many parameter bytes it takes: zero, one, two, fifteen or sixty-four. It collects those bytes and then updates the registers that the address generator and the row drive sequencer read. These registers cover the column and row windows, the remap flags, the display mode, the multiplex ratio, sleep, contrast, the start line, the line offset, the gray-level pulse-width table and the per-icon current table.

Multi-byte commands are applied as a whole, on the cycle their last parameter arrives. A command byte that arrives while parameters are still expected abandons the pending command and is decoded as a new opcode. A lock command freezes the interface so that only the unlock sequence is honoured. A status byte reports whether the panel is asleep.

Top module: `dpc_cmd_parser`

## Requirements
- R1: After reset: column window 0..63, row window 0..127, contrast 0x80, all remap flags 0, display mode normal (0), multiplex value 127, start line 0, offset 0, sleeping 1, every icon level 0, gray level k (1..15) holds 4k-3, interface unlocked.
- R2: Opcode 0x15 takes a start then an end column, and 0x75 takes a start then an end row. Each pair is applied together on the cycle after the second byte. Column values above 63 clamp to 63 and row values above 127 clamp to 127.
- R3: Opcode 0x81 loads contrast with its 8-bit parameter. Opcode 0xa0 loads the remap flags from its parameter: bit0 column reverse, bit1 nibble swap, bit2 vertical increment, bit4 COM reverse, bit6 odd/even COM split. The other bits are ignored.
- R4: The parameterless opcodes 0xa4, 0xa5, 0xa6 and 0xa7 set the display mode output to 0 (normal), 1 (all at GS15), 2 (all at GS0) and 3 (inverted).
- R5: Opcode 0xa8 takes one byte. A value below 15 is stored as 15 and a value above 127 as 127, so the multiplex value stays within 15..127 (16..128 rows).
- R6: Opcode 0xae sets sleeping and 0xaf clears it. The status output equals 0x40 while sleeping and 0x00 otherwise.
- R7: Opcode 0xb8 takes 15 bytes for gray levels 1 to 15 in order. Each byte clamps to 63, and the table updates only after the 15th byte. Opcode 0xb7, which takes no parameters, restores the reset table.
- R8: Opcode 0x92 takes 64 bytes for icons 0 to 63 in order. Each byte clamps to 127, and no icon level changes until the 64th byte has arrived.
- R9: Opcode 0xfd with parameter 0x13 locks and with 0x12 unlocks. Any other parameter leaves the lock state as it is. While locked, every command byte other than 0xfd, and every data byte that does not belong to a 0xfd, has no effect.
- R10: A command byte that arrives before a pending command has all of its parameters discards that command with no effect and is decoded as a new opcode.
- R11: An unknown opcode has no effect and opens no parameter sequence, so data bytes that follow it are ignored. Opcode 0xe3 does nothing.
- R12: Opcodes 0xa1 (start line) and 0xa2 (line offset) each take one byte, which clamps to 127.
- R13: A data byte with no command pending, and any byte presented while the valid strobe is low, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | Byte strobe, one byte per cycle when high |
| is_cmd | input | 1 | 1 = byte is an opcode, 0 = byte is a parameter |
| byte_in | input | 8 | Incoming byte |
| col_start | output | COL_W | Column window start |
| col_end | output | COL_W | Column window end |
| row_start | output | ROW_W | Row window start |
| row_end | output | ROW_W | Row window end |
| contrast | output | 8 | Contrast step |
| remap_col | output | 1 | Column order reversed |
| remap_nibble | output | 1 | Pixel nibbles swapped in data bytes |
| vert_incr | output | 1 | Address advances down rows first |
| com_reverse | output | 1 | COM scan bottom to top |
| com_split | output | 1 | Odd/even COM split |
| disp_mode | output | 2 | 0 normal, 1 all GS15, 2 all GS0, 3 inverted |
| mux_ratio | output | ROW_W | Multiplex value (rows minus one) |
| start_line | output | ROW_W | First RAM row shown |
| line_offset | output | ROW_W | Vertical COM offset |
| sleeping | output | 1 | Panel off |
| status | output | 8 | Status byte, bit 6 = sleeping |
| gray_pw | output | GRAY_N*GRAY_W | Pulse widths, level 1 in the lowest field |
| icon_lvl | output | ICON_N*ICON_W | Icon currents, icon 0 in the lowest field |

## Verification
The stimulus covers each parameter count: no parameters (display modes, sleep, the table reset), one byte with in-range and out-of-range values, the two-byte windows, and the long 15- and 64-byte streams. Comparing every cycle inside the long streams shows whether the table changes early or only on the last byte. Interrupted sequences, unknown opcodes followed by stray data, and data with nothing pending separate correct parameter counting from a parser that consumes or applies stray bytes. A locked phase that sends every kind of command, plus a 0xfd with an unrelated parameter, tells a true lock apart from one that drops only some traffic or releases on any 0xfd.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  localparam logic [7:0] OP_COLWIN   = 8'h15;
  localparam logic [7:0] OP_ROWWIN   = 8'h75;
  localparam logic [7:0] OP_CONTRAST = 8'h81;
  localparam logic [7:0] OP_ICONCUR  = 8'h92;
  localparam logic [7:0] OP_REMAP    = 8'ha0;
  localparam logic [7:0] OP_STARTLN  = 8'ha1;
  localparam logic [7:0] OP_OFFSET   = 8'ha2;
  localparam logic [7:0] OP_MODE_NRM = 8'ha4;
  localparam logic [7:0] OP_MODE_ON  = 8'ha5;
  localparam logic [7:0] OP_MODE_OFF = 8'ha6;
  localparam logic [7:0] OP_MODE_INV = 8'ha7;
  localparam logic [7:0] OP_MUX      = 8'ha8;
  localparam logic [7:0] OP_SLEEP_ON = 8'hae;
  localparam logic [7:0] OP_WAKE     = 8'haf;
  localparam logic [7:0] OP_GRAYDEF  = 8'hb7;
  localparam logic [7:0] OP_GRAYTAB  = 8'hb8;
  localparam logic [7:0] OP_NOP      = 8'he3;
  localparam logic [7:0] OP_LOCK     = 8'hfd;

  localparam logic [7:0] LOCK_SET    = 8'h13;
  localparam logic [7:0] LOCK_CLEAR  = 8'h12;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_ALL_ON  = 2'd1,
    MODE_ALL_OFF = 2'd2,
    MODE_INVERT  = 2'd3
  } disp_mode_e;

  // Limit an unsigned byte to [lo, hi].
  function automatic logic [7:0] clamp8(input logic [7:0] v,
                                        input logic [7:0] lo,
                                        input logic [7:0] hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Parameter bytes an opcode takes; -1 for an unknown opcode.
  function automatic int param_count(input logic [7:0] op,
                                     input int icon_n,
                                     input int gray_n);
    case (op)
      OP_COLWIN, OP_ROWWIN:                         return 2;
      OP_CONTRAST, OP_REMAP, OP_STARTLN, OP_OFFSET,
      OP_MUX, OP_LOCK:                              return 1;
      OP_MODE_NRM, OP_MODE_ON, OP_MODE_OFF, OP_MODE_INV,
      OP_SLEEP_ON, OP_WAKE, OP_GRAYDEF, OP_NOP:     return 0;
      OP_GRAYTAB:                                   return gray_n;
      OP_ICONCUR:                                   return icon_n;
      default:                                      return -1;
    endcase
  endfunction

  // Reset pulse width of gray level k (k counts from 1).
  function automatic int gray_default(input int k);
    return 4 * k - 3;
  endfunction

endpackage

// File: rtl/dpc_decode.sv
module dpc_decode
  import dpc_pkg::*;
#(
  parameter int ICON_N = 64,
  parameter int GRAY_N = 15,
  parameter int CNT_W  = 7
) (
  input  logic [7:0]       op,
  output logic             known,
  output logic [CNT_W-1:0] nparams
);

  int cnt;

  always_comb begin
    cnt     = param_count(op, ICON_N, GRAY_N);
    known   = (cnt >= 0);
    nparams = known ? CNT_W'(cnt) : '0;
  end

endmodule

// File: rtl/dpc_seq.sv
module dpc_seq
  import dpc_pkg::*;
#(
  parameter int ICON_N = 64,
  parameter int GRAY_N = 15,
  parameter int CNT_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             is_cmd,
  input  logic [7:0]       byte_in,
  output logic             exec0_evt,
  output logic             param_evt,
  output logic             param_last,
  output logic [7:0]       param_op,
  output logic [CNT_W-1:0] param_idx,
  output logic             locked
);

  logic             busy_q;
  logic [7:0]       op_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] need_q;
  logic             known;
  logic [CNT_W-1:0] nparams;
  logic             cmd_seen;
  logic             cmd_take;

  dpc_decode #(.ICON_N(ICON_N), .GRAY_N(GRAY_N), .CNT_W(CNT_W)) u_dec (
    .op      (byte_in),
    .known   (known),
    .nparams (nparams)
  );

  always_comb begin
    cmd_seen   = byte_vld && is_cmd;
    cmd_take   = cmd_seen && known && (!locked || byte_in == OP_LOCK);
    exec0_evt  = cmd_take && (nparams == '0);
    param_evt  = byte_vld && !is_cmd && busy_q;
    param_last = param_evt && (idx_q == need_q - CNT_W'(1));
    param_op   = op_q;
    param_idx  = idx_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= '0;
      idx_q  <= '0;
      need_q <= '0;
      locked <= 1'b0;
    end else begin
      if (cmd_seen) begin
        // any command byte ends what was pending
        busy_q <= cmd_take && (nparams != '0);
        op_q   <= byte_in;
        idx_q  <= '0;
        need_q <= nparams;
      end else if (param_evt) begin
        idx_q <= idx_q + CNT_W'(1);
        if (param_last) busy_q <= 1'b0;
      end
      if (param_last && op_q == OP_LOCK) begin
        if (byte_in == LOCK_SET)        locked <= 1'b1;
        else if (byte_in == LOCK_CLEAR) locked <= 1'b0;
      end
    end
  end

  // R9: while locked, the only command that can be collecting bytes is the lock command
  a_r9_locked_only_lock: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (!busy_q || op_q == OP_LOCK));

  // R11: an unknown opcode never leaves a parameter sequence open
  a_r11_unknown_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && is_cmd && !known) |=> !busy_q);

endmodule

// File: rtl/dpc_regs.sv
module dpc_regs
  import dpc_pkg::*;
#(
  parameter int COL_W  = 6,
  parameter int ROW_W  = 7,
  parameter int GRAY_N = 15,
  parameter int GRAY_W = 6,
  parameter int ICON_N = 64,
  parameter int ICON_W = 7,
  parameter int CNT_W  = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [7:0]               byte_in,
  input  logic                     exec0_evt,
  input  logic                     param_evt,
  input  logic                     param_last,
  input  logic [7:0]               param_op,
  input  logic [CNT_W-1:0]         param_idx,
  output logic [COL_W-1:0]         col_start,
  output logic [COL_W-1:0]         col_end,
  output logic [ROW_W-1:0]         row_start,
  output logic [ROW_W-1:0]         row_end,
  output logic [7:0]               contrast,
  output logic [4:0]               remap_bits,
  output logic [1:0]               disp_mode,
  output logic [ROW_W-1:0]         mux_ratio,
  output logic [ROW_W-1:0]         start_line,
  output logic [ROW_W-1:0]         line_offset,
  output logic                     sleeping,
  output logic [GRAY_N*GRAY_W-1:0] gray_flat,
  output logic [ICON_N*ICON_W-1:0] icon_flat
);

  localparam logic [7:0] COL_MAX8  = 8'((1 << COL_W) - 1);
  localparam logic [7:0] ROW_MAX8  = 8'((1 << ROW_W) - 1);
  localparam logic [7:0] GRAY_MAX8 = 8'((1 << GRAY_W) - 1);
  localparam logic [7:0] ICON_MAX8 = 8'((1 << ICON_W) - 1);
  localparam logic [7:0] MUX_MIN8  = 8'd15;

  logic [7:0]        stage0;
  logic [GRAY_W-1:0] gray_q   [GRAY_N];
  logic [GRAY_W-1:0] gray_stg [GRAY_N];
  logic [GRAY_W-1:0] gray_def [GRAY_N];
  logic [ICON_W-1:0] icon_q   [ICON_N];
  logic [ICON_W-1:0] icon_stg [ICON_N];

  logic [7:0] cl_col, cl_scol, cl_row, cl_srow, cl_mux, cl_gray, cl_icon;
  logic [COL_W-1:0]  new_col, new_scol;
  logic [ROW_W-1:0]  new_row, new_srow, new_mux;
  logic [GRAY_W-1:0] new_gray;
  logic [ICON_W-1:0] new_icon;
  logic              gray_commit, icon_commit;

  always_comb begin
    cl_col   = clamp8(byte_in, 8'd0, COL_MAX8);
    cl_scol  = clamp8(stage0,  8'd0, COL_MAX8);
    cl_row   = clamp8(byte_in, 8'd0, ROW_MAX8);
    cl_srow  = clamp8(stage0,  8'd0, ROW_MAX8);
    cl_mux   = clamp8(byte_in, MUX_MIN8, ROW_MAX8);
    cl_gray  = clamp8(byte_in, 8'd0, GRAY_MAX8);
    cl_icon  = clamp8(byte_in, 8'd0, ICON_MAX8);
    new_col  = cl_col[COL_W-1:0];
    new_scol = cl_scol[COL_W-1:0];
    new_row  = cl_row[ROW_W-1:0];
    new_srow = cl_srow[ROW_W-1:0];
    new_mux  = cl_mux[ROW_W-1:0];
    new_gray = cl_gray[GRAY_W-1:0];
    new_icon = cl_icon[ICON_W-1:0];
    gray_commit = param_last && param_op == OP_GRAYTAB;
    icon_commit = param_last && param_op == OP_ICONCUR;
  end

  for (genvar g = 0; g < GRAY_N; g++) begin : g_gray
    localparam int GD = gray_default(g + 1);
    localparam logic [7:0] GD8 = 8'(GD);
    assign gray_def[g] = GD8[GRAY_W-1:0];
    assign gray_flat[g*GRAY_W +: GRAY_W] = gray_q[g];
  end

  for (genvar i = 0; i < ICON_N; i++) begin : g_icon
    assign icon_flat[i*ICON_W +: ICON_W] = icon_q[i];
  end

  // scalar configuration
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage0      <= '0;
      col_start   <= '0;
      col_end     <= COL_MAX8[COL_W-1:0];
      row_start   <= '0;
      row_end     <= ROW_MAX8[ROW_W-1:0];
      contrast    <= 8'h80;
      remap_bits  <= '0;
      disp_mode   <= MODE_NORMAL;
      mux_ratio   <= ROW_MAX8[ROW_W-1:0];
      start_line  <= '0;
      line_offset <= '0;
      sleeping    <= 1'b1;
    end else if (exec0_evt) begin
      case (byte_in)
        OP_MODE_NRM: disp_mode <= MODE_NORMAL;
        OP_MODE_ON:  disp_mode <= MODE_ALL_ON;
        OP_MODE_OFF: disp_mode <= MODE_ALL_OFF;
        OP_MODE_INV: disp_mode <= MODE_INVERT;
        OP_SLEEP_ON: sleeping  <= 1'b1;
        OP_WAKE:     sleeping  <= 1'b0;
        default: ;
      endcase
    end else if (param_evt) begin
      case (param_op)
        OP_COLWIN: begin
          if (!param_last) stage0 <= byte_in;
          else begin
            col_start <= new_scol;
            col_end   <= new_col;
          end
        end
        OP_ROWWIN: begin
          if (!param_last) stage0 <= byte_in;
          else begin
            row_start <= new_srow;
            row_end   <= new_row;
          end
        end
        OP_CONTRAST: contrast    <= byte_in;
        OP_REMAP:    remap_bits  <= {byte_in[6], byte_in[4], byte_in[2:0]};
        OP_STARTLN:  start_line  <= new_row;
        OP_OFFSET:   line_offset <= new_row;
        OP_MUX:      mux_ratio   <= new_mux;
        default: ;
      endcase
    end
  end

  // gray table: staged bytes, applied together on the last one
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < GRAY_N; g++) begin
        gray_q[g]   <= gray_def[g];
        gray_stg[g] <= '0;
      end
    end else if (exec0_evt && byte_in == OP_GRAYDEF) begin
      for (int g = 0; g < GRAY_N; g++) gray_q[g] <= gray_def[g];
    end else if (param_evt && param_op == OP_GRAYTAB) begin
      for (int g = 0; g < GRAY_N; g++) begin
        if (param_idx == CNT_W'(g)) gray_stg[g] <= new_gray;
        if (gray_commit)
          gray_q[g] <= (param_idx == CNT_W'(g)) ? new_gray : gray_stg[g];
      end
    end
  end

  // icon current table: same staging scheme
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ICON_N; i++) begin
        icon_q[i]   <= '0;
        icon_stg[i] <= '0;
      end
    end else if (param_evt && param_op == OP_ICONCUR) begin
      for (int i = 0; i < ICON_N; i++) begin
        if (param_idx == CNT_W'(i)) icon_stg[i] <= new_icon;
        if (icon_commit)
          icon_q[i] <= (param_idx == CNT_W'(i)) ? new_icon : icon_stg[i];
      end
    end
  end

  // R8: icon levels move only on the final byte of the icon command
  a_r8_icon_atomic: assert property (@(posedge clk) disable iff (!rst_n)
    !icon_commit |=> $stable(icon_flat));

  // R7: gray table moves only on its final byte or on the restore command
  a_r7_gray_atomic: assert property (@(posedge clk) disable iff (!rst_n)
    (!gray_commit && !(exec0_evt && byte_in == OP_GRAYDEF)) |=> $stable(gray_flat));

  // R2: a window pair changes only when its second byte arrives
  a_r2_window_atomic: assert property (@(posedge clk) disable iff (!rst_n)
    !(param_last && param_op == OP_COLWIN) |=> ($stable(col_start) && $stable(col_end)));

endmodule

// File: rtl/dpc_cmd_parser.sv
module dpc_cmd_parser
  import dpc_pkg::*;
#(
  parameter int COL_W  = 6,
  parameter int ROW_W  = 7,
  parameter int GRAY_N = 15,
  parameter int GRAY_W = 6,
  parameter int ICON_N = 64,
  parameter int ICON_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     byte_vld,
  input  logic                     is_cmd,
  input  logic [7:0]               byte_in,
  output logic [COL_W-1:0]         col_start,
  output logic [COL_W-1:0]         col_end,
  output logic [ROW_W-1:0]         row_start,
  output logic [ROW_W-1:0]         row_end,
  output logic [7:0]               contrast,
  output logic                     remap_col,
  output logic                     remap_nibble,
  output logic                     vert_incr,
  output logic                     com_reverse,
  output logic                     com_split,
  output logic [1:0]               disp_mode,
  output logic [ROW_W-1:0]         mux_ratio,
  output logic [ROW_W-1:0]         start_line,
  output logic [ROW_W-1:0]         line_offset,
  output logic                     sleeping,
  output logic [7:0]               status,
  output logic [GRAY_N*GRAY_W-1:0] gray_pw,
  output logic [ICON_N*ICON_W-1:0] icon_lvl
);

  localparam int MAXP  = (ICON_N > GRAY_N) ? ICON_N : GRAY_N;
  localparam int CNT_W = $clog2(MAXP + 1);
  localparam logic [ROW_W-1:0] MUX_MIN = ROW_W'(15);

  logic             exec0_evt;
  logic             param_evt;
  logic             param_last;
  logic [7:0]       param_op;
  logic [CNT_W-1:0] param_idx;
  logic             locked;
  logic [4:0]       remap_bits;

  dpc_seq #(.ICON_N(ICON_N), .GRAY_N(GRAY_N), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld   (byte_vld),
    .is_cmd     (is_cmd),
    .byte_in    (byte_in),
    .exec0_evt  (exec0_evt),
    .param_evt  (param_evt),
    .param_last (param_last),
    .param_op   (param_op),
    .param_idx  (param_idx),
    .locked     (locked)
  );

  dpc_regs #(
    .COL_W(COL_W), .ROW_W(ROW_W), .GRAY_N(GRAY_N), .GRAY_W(GRAY_W),
    .ICON_N(ICON_N), .ICON_W(ICON_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_in     (byte_in),
    .exec0_evt   (exec0_evt),
    .param_evt   (param_evt),
    .param_last  (param_last),
    .param_op    (param_op),
    .param_idx   (param_idx),
    .col_start   (col_start),
    .col_end     (col_end),
    .row_start   (row_start),
    .row_end     (row_end),
    .contrast    (contrast),
    .remap_bits  (remap_bits),
    .disp_mode   (disp_mode),
    .mux_ratio   (mux_ratio),
    .start_line  (start_line),
    .line_offset (line_offset),
    .sleeping    (sleeping),
    .gray_flat   (gray_pw),
    .icon_flat   (icon_lvl)
  );

  assign remap_col    = remap_bits[0];
  assign remap_nibble = remap_bits[1];
  assign vert_incr    = remap_bits[2];
  assign com_reverse  = remap_bits[3];
  assign com_split    = remap_bits[4];
  assign status       = {1'b0, sleeping, 6'b0};

  // R9: a locked interface leaves mode, sleep and contrast untouched
  a_r9_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && byte_vld && is_cmd && byte_in != OP_LOCK)
      |=> ($stable(disp_mode) && $stable(sleeping) && $stable(contrast)));

  // R6: the sleep opcode, when accepted, shows up in the status byte next cycle
  a_r6_sleep_status: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && byte_vld && is_cmd && byte_in == OP_SLEEP_ON) |=> (sleeping && status[6]));

  // R5: multiplex value never drops below its floor
  a_r5_mux_floor: assert property (@(posedge clk) disable iff (!rst_n)
    mux_ratio >= MUX_MIN);

  // R13: data with nothing pending never opens a change
  a_r13_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !is_cmd && !param_evt) |=> ($stable(contrast) && $stable(mux_ratio)));

endmodule

// File: tb/dpc_cmd_parser_tb.sv
`timescale 1ns/1ps
module dpc_cmd_parser_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_vld = 1'b0;
  logic        is_cmd = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic [5:0]  col_start, col_end;
  logic [6:0]  row_start, row_end;
  logic [7:0]  contrast;
  logic        remap_col, remap_nibble, vert_incr, com_reverse, com_split;
  logic [1:0]  disp_mode;
  logic [6:0]  mux_ratio, start_line, line_offset;
  logic        sleeping;
  logic [7:0]  status;
  logic [89:0] gray_pw;
  logic [447:0] icon_lvl;

  always #4 clk = ~clk;

  dpc_cmd_parser u_dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .is_cmd(is_cmd), .byte_in(byte_in),
    .col_start(col_start), .col_end(col_end), .row_start(row_start), .row_end(row_end),
    .contrast(contrast), .remap_col(remap_col), .remap_nibble(remap_nibble),
    .vert_incr(vert_incr), .com_reverse(com_reverse), .com_split(com_split),
    .disp_mode(disp_mode), .mux_ratio(mux_ratio), .start_line(start_line),
    .line_offset(line_offset), .sleeping(sleeping), .status(status),
    .gray_pw(gray_pw), .icon_lvl(icon_lvl)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string phase = "R1";

  // reference model state
  int m_cs, m_ce, m_rs, m_re, m_con, m_remap, m_mode, m_mux, m_sl, m_off, m_sleep;
  int m_gray[16];
  int m_icon[64];
  bit m_locked;
  int m_op;
  int m_need;
  int m_q[$];

  function automatic int lim(int v, int lo, int hi);
    if (v < lo) return lo;
    else if (v > hi) return hi;
    return v;
  endfunction

  function automatic int need_of(int op);
    if (op == 'h15 || op == 'h75) return 2;
    if (op == 'h81 || op == 'ha0 || op == 'ha1 || op == 'ha2 || op == 'ha8 || op == 'hfd) return 1;
    if ((op >= 'ha4 && op <= 'ha7) || op == 'hae || op == 'haf || op == 'hb7 || op == 'he3) return 0;
    if (op == 'hb8) return 15;
    if (op == 'h92) return 64;
    return -1;
  endfunction

  task automatic model_reset();
    m_cs = 0; m_ce = 63; m_rs = 0; m_re = 127; m_con = 128; m_remap = 0;
    m_mode = 0; m_mux = 127; m_sl = 0; m_off = 0; m_sleep = 1;
    for (int k = 1; k <= 15; k++) m_gray[k] = 4 * k - 3;
    for (int i = 0; i < 64; i++) m_icon[i] = 0;
    m_locked = 0; m_op = -1; m_need = 0; m_q.delete();
  endtask

  task automatic model_run();
    case (m_op)
      'h15: begin m_cs = lim(m_q[0], 0, 63);  m_ce = lim(m_q[1], 0, 63);  end
      'h75: begin m_rs = lim(m_q[0], 0, 127); m_re = lim(m_q[1], 0, 127); end
      'h81: m_con = m_q[0];
      'ha0: m_remap = m_q[0] & 'h57;
      'ha1: m_sl = lim(m_q[0], 0, 127);
      'ha2: m_off = lim(m_q[0], 0, 127);
      'ha8: m_mux = lim(m_q[0], 15, 127);
      'hb8: for (int k = 1; k <= 15; k++) m_gray[k] = lim(m_q[k-1], 0, 63);
      'h92: for (int i = 0; i < 64; i++) m_icon[i] = lim(m_q[i], 0, 127);
      'hfd: begin
        if (m_q[0] == 'h13) m_locked = 1;
        else if (m_q[0] == 'h12) m_locked = 0;
      end
      default: ;
    endcase
  endtask

  task automatic model_byte(bit c, int b);
    if (c) begin
      m_op = -1; m_q.delete();
      if (m_locked && b != 'hfd) return;
      if (need_of(b) < 0) return;
      if (need_of(b) == 0) begin
        if (b >= 'ha4 && b <= 'ha7) m_mode = b - 'ha4;
        else if (b == 'hae) m_sleep = 1;
        else if (b == 'haf) m_sleep = 0;
        else if (b == 'hb7) for (int k = 1; k <= 15; k++) m_gray[k] = 4 * k - 3;
      end else begin
        m_op = b; m_need = need_of(b);
      end
    end else begin
      if (m_op < 0) return;
      m_q.push_back(b);
      if (m_q.size() == m_need) begin
        model_run();
        m_op = -1; m_q.delete();
      end
    end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s (stimulus %s): actual %0d expected %0d", tag, what, phase, act, exp);
    end
  endtask

  task automatic compare_all();
    int ra;
    ra = {com_split, 1'b0, com_reverse, 1'b0, vert_incr, remap_nibble, remap_col};
    chk("R2", "col_start", col_start, m_cs);
    chk("R2", "col_end", col_end, m_ce);
    chk("R2", "row_start", row_start, m_rs);
    chk("R2", "row_end", row_end, m_re);
    chk("R3", "contrast", contrast, m_con);
    chk("R3", "remap", ra, m_remap);
    chk("R4", "disp_mode", disp_mode, m_mode);
    chk("R5", "mux_ratio", mux_ratio, m_mux);
    chk("R12", "start_line", start_line, m_sl);
    chk("R12", "line_offset", line_offset, m_off);
    chk("R6", "sleeping", sleeping, m_sleep);
    chk("R6", "status", status, m_sleep ? 'h40 : 0);
    for (int k = 1; k <= 15; k++)
      chk("R7", $sformatf("gray level %0d", k), gray_pw[(k-1)*6 +: 6], m_gray[k]);
    for (int i = 0; i < 64; i++)
      chk("R8", $sformatf("icon %0d", i), icon_lvl[i*7 +: 7], m_icon[i]);
  endtask

  task automatic send(bit c, int b);
    @(negedge clk);
    byte_vld = 1'b1; is_cmd = c; byte_in = 8'(b);
    model_byte(c, b);
    @(posedge clk); #1;
    byte_vld = 1'b0;
    compare_all();
  endtask

  task automatic idle_junk(int b);
    @(negedge clk);
    byte_vld = 1'b0; is_cmd = b[0]; byte_in = 8'(b);
    @(posedge clk); #1;
    compare_all();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    phase = "R1"; compare_all();
    @(negedge clk); rst_n = 1'b1;

    phase = "R2";
    send(1, 'h15); send(0, 5); send(0, 40);
    send(1, 'h15); send(0, 70); send(0, 2);
    send(1, 'h75); send(0, 10); send(0, 100);
    send(1, 'h75); send(0, 200); send(0, 0);

    phase = "R3";
    send(1, 'h81); send(0, 'h33);
    send(1, 'ha0); send(0, 'h57);
    send(1, 'ha0); send(0, 'ha8);
    send(1, 'ha0); send(0, 'h05);

    phase = "R4";
    send(1, 'ha5); send(1, 'ha6); send(1, 'ha7); send(1, 'ha4);

    phase = "R5";
    send(1, 'ha8); send(0, 3);
    send(1, 'ha8); send(0, 63);
    send(1, 'ha8); send(0, 200);
    send(1, 'ha8); send(0, 15);

    phase = "R6";
    send(1, 'haf); send(1, 'hae); send(1, 'haf);

    phase = "R12";
    send(1, 'ha1); send(0, 20);
    send(1, 'ha2); send(0, 150);

    phase = "R7";
    send(1, 'hb8);
    for (int k = 1; k <= 15; k++) send(0, (k == 7) ? 100 : k * 3);
    send(1, 'hb7);

    phase = "R8";
    send(1, 'h92);
    for (int i = 0; i < 64; i++) send(0, (i * 3) & 'hff);

    phase = "R10";
    send(1, 'h92);
    for (int i = 0; i < 10; i++) send(0, 5);
    send(1, 'h81); send(0, 'h11);
    send(1, 'h15); send(0, 7); send(1, 'ha6);
    send(0, 9);
    send(1, 'hb8); send(0, 1); send(0, 2); send(1, 'ha4);

    phase = "R11";
    send(1, 'h42); send(0, 'h99); send(0, 'h01);
    send(1, 'he3); send(0, 'h22);
    send(1, 'h00); send(0, 'h81);

    phase = "R13";
    send(0, 'h12); send(0, 'hff);
    send(1, 'h81); idle_junk('h44); idle_junk('h45); send(0, 'h66);
    send(1, 'h81); idle_junk('h81);

    phase = "R9";
    send(1, 'hfd); send(0, 'h13);
    send(1, 'h81); send(0, 'h55);
    send(1, 'hae); send(1, 'ha7);
    send(1, 'h15); send(0, 1); send(0, 2);
    send(1, 'hb7);
    send(1, 'hfd); send(0, 'h77);
    send(1, 'ha5);
    send(1, 'hfd); send(0, 'h12);
    send(1, 'h81); send(0, 'h55);
    send(1, 'ha7);

    summary();
  end

endmodule